// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that is held in word-addressed memory. A request carries the virtual address, a privilege flag (supervisor or user) and a write flag. The privilege flag chooses one of two root frame numbers, and that root locates the top-level table. The top-level entry gives the frame of a second-level table. The second-level entry gives the physical frame, a read-only flag, a cache-inhibit flag and two usage flags, which the walker keeps up to date.

The walker reads memory through a request/acknowledge port, one word per transfer. It checks validity and write permission at both levels. When the usage flags of the page entry must change, it writes that entry back. A walk ends with a one-cycle done pulse. The pulse comes with either a physical address plus its cache-inhibit flag, or a fault kind plus the virtual address that caused it. Only one walk runs at a time.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and `mem_req` is 0.
- R2: The first memory read of a walk uses the address (root << 12) + VA[31:22]*4. The root is `sup_root` when `req_super` is 1 and `usr_root` when it is 0.
- R3: Once the top-level entry is valid and allowed, the second read uses the address (entry[31:12] << 12) + VA[21:12]*4. While `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` stay unchanged.
- R4: A top-level entry is valid only when its bit 1 is set. Bit 0 does not count. An invalid entry ends the walk with fault code 1 (table fault), after one read and with no write.
- R5: A page entry is valid only when its bit 0 is set. Bit 1 does not count. An invalid page entry ends the walk with fault code 2 (page fault) and no write.
- R6: A write request ends with fault code 3 (protection fault) in two cases. If the top-level entry has bit 2 set, the walk stops after one read. If the page entry has bit 2 set, the walk stops with no write. Read requests through read-only entries succeed.
- R7: On success the fault code is 0. The physical address is page-entry bits 31:12 joined with VA[11:0], and `rsp_nocache` equals page-entry bit 6.
- R8: On success the walker sets the reference flag (bit 3) in the page entry. On a successful write it also sets the modify flag (bit 4). It writes the updated word to the page-entry address only when the word differs from the word it read. Otherwise no write is made.
- R9: On any fault, no memory write takes place during the walk, and `rsp_fault_va` equals the request's virtual address.
- R10: `req_ready` goes low when a request is accepted and stays low until the one-cycle `rsp_done` pulse. It is high in the cycle after the pulse. Requests offered while the walker is busy are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_write | input | 1 | 1 = write access |
| sup_root | input | 20 | Frame number of the supervisor top-level table |
| usr_root | input | 20 | Frame number of the user top-level table |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write transfer |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Updated page entry for write-back |
| mem_ack | input | 1 | Transfer complete; read data valid this cycle |
| mem_rdata | input | 32 | Entry word read |
| rsp_done | output | 1 | One-cycle pulse: the walk has ended |
| rsp_fault | output | 2 | 0 none, 1 table fault, 2 page fault, 3 protection fault |
| rsp_paddr | output | 32 | Physical address (valid when the fault code is 0) |
| rsp_nocache | output | 1 | Cache-inhibit flag of the translated page |
| rsp_fault_va | output | 32 | Virtual address of the ended walk |

## Verification
Some properties are checked on every cycle, whatever the table contents. The first read address must follow from the selected root and the top index. A pending transfer must hold its address steady. Any write-back must target the word just read and must carry the reference flag. A faulted walk must never have written, and its reported address must match the request. The done pulse must be single and must be followed by readiness. Other behaviours depend on entry contents, so only the directed scenarios can show them. These are: which bit gives validity at each level, the three fault kinds, the exact physical frame and cache-inhibit value, whether the modify flag is set, and the omission of a write-back when the flags are already set.

// File: rtl/xw_pkg.sv
// Shared types and entry bit positions for the translation walker.
// Assumes 32-bit entries; bit positions are fixed by the table format.
package xw_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_TABLE = 2'd1,
        FLT_PAGE  = 2'd2,
        FLT_PROT  = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG,
        ST_PAGE,
        ST_WB,
        ST_DONE
    } st_e;

    localparam int SEG_VALID_BIT = 1;
    localparam int PG_VALID_BIT  = 0;
    localparam int RO_BIT        = 2;
    localparam int REF_BIT       = 3;
    localparam int MOD_BIT       = 4;
    localparam int NOCACHE_BIT   = 6;
endpackage

// File: rtl/xw_entry_addr.sv
// Forms the byte address of a table entry from a frame number and an index.
// Assumes 4-byte entries and tables that fit inside one frame.
module xw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFFS_W-1:0] base_frame,
    input  logic [IDX_W-1:0]         index,
    output logic [ADDR_W-1:0]        entry_addr
);
    localparam int FRM_W = ADDR_W - OFFS_W;

    // frame base plus word-scaled index
    always_comb begin
        entry_addr = {base_frame, {OFFS_W{1'b0}}} + ADDR_W'({index, 2'b00});
    end
endmodule

// File: rtl/xw_entry_decode.sv
// Decodes one table entry: frame, validity, write-permission error.
// When HAS_FLAGS is set, it also forms the entry with usage flags updated.
// Assumes the entry word is presented only while its ack is high.
module xw_entry_decode #(
    parameter int ADDR_W    = 32,
    parameter int OFFS_W    = 12,
    parameter int VALID_POS = 0,
    parameter bit HAS_FLAGS = 1'b0
) (
    input  logic [ADDR_W-1:0]        entry,
    input  logic                     is_write,
    output logic [ADDR_W-OFFS_W-1:0] frame,
    output logic                     valid,
    output logic                     prot_err,
    output logic [ADDR_W-1:0]        updated,
    output logic                     changed
);
    import xw_pkg::*;

    // field extraction and permission check
    always_comb begin
        frame    = entry[ADDR_W-1:OFFS_W];
        valid    = entry[VALID_POS];
        prot_err = is_write && entry[RO_BIT];
    end

    generate
        if (HAS_FLAGS) begin : g_flags
            // set the reference flag always, the modify flag on writes
            always_comb begin
                updated          = entry;
                updated[REF_BIT] = 1'b1;
                if (is_write) updated[MOD_BIT] = 1'b1;
                changed          = (updated != entry);
            end
        end else begin : g_noflags
            // top-level entries are never written back
            always_comb begin
                updated = entry;
                changed = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation walker. Reads the top-level entry, then the page
// entry, checks validity and write permission, writes back usage flags
// when they change, and reports a physical address or a fault kind.
// Assumes one outstanding memory transfer, with ack valid for one cycle.
module xlat_walker #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_vaddr,
    input  logic                     req_super,
    input  logic                     req_write,
    input  logic [ADDR_W-OFFS_W-1:0] sup_root,
    input  logic [ADDR_W-OFFS_W-1:0] usr_root,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [ADDR_W-1:0]        mem_wdata,
    input  logic                     mem_ack,
    input  logic [ADDR_W-1:0]        mem_rdata,
    output logic                     rsp_done,
    output logic [1:0]               rsp_fault,
    output logic [ADDR_W-1:0]        rsp_paddr,
    output logic                     rsp_nocache,
    output logic [ADDR_W-1:0]        rsp_fault_va
);
    import xw_pkg::*;

    localparam int FRM_W = ADDR_W - OFFS_W;

    st_e               st;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic [FRM_W-1:0]  root_q;
    logic [FRM_W-1:0]  ptf_q;
    logic [ADDR_W-1:0] pa_q;
    logic              nc_q;
    logic [ADDR_W-1:0] wb_q;
    flt_e              flt_q;

    logic [IDX_W-1:0]  seg_idx, pg_idx;
    logic [ADDR_W-1:0] seg_addr, pg_addr;
    logic [FRM_W-1:0]  seg_frame, pg_frame;
    logic              seg_ok, seg_prot, pg_ok, pg_prot;
    logic [ADDR_W-1:0] seg_upd, pg_upd;
    logic              seg_chg, pg_chg;

    // split the latched virtual address into table indexes
    always_comb begin
        seg_idx = va_q[ADDR_W-1 -: IDX_W];
        pg_idx  = va_q[OFFS_W+IDX_W-1 -: IDX_W];
    end

    xw_entry_addr #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_seg_addr (
        .base_frame(root_q), .index(seg_idx), .entry_addr(seg_addr)
    );

    xw_entry_addr #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_pg_addr (
        .base_frame(ptf_q), .index(pg_idx), .entry_addr(pg_addr)
    );

    xw_entry_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
                      .VALID_POS(SEG_VALID_BIT), .HAS_FLAGS(1'b0)) u_seg_dec (
        .entry(mem_rdata), .is_write(wr_q), .frame(seg_frame), .valid(seg_ok),
        .prot_err(seg_prot), .updated(seg_upd), .changed(seg_chg)
    );

    xw_entry_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
                      .VALID_POS(PG_VALID_BIT), .HAS_FLAGS(1'b1)) u_pg_dec (
        .entry(mem_rdata), .is_write(wr_q), .frame(pg_frame), .valid(pg_ok),
        .prot_err(pg_prot), .updated(pg_upd), .changed(pg_chg)
    );

    // walk sequencing, result capture and fault classification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            va_q   <= '0;
            wr_q   <= 1'b0;
            root_q <= '0;
            ptf_q  <= '0;
            pa_q   <= '0;
            nc_q   <= 1'b0;
            wb_q   <= '0;
            flt_q  <= FLT_NONE;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    root_q <= req_super ? sup_root : usr_root;
                    flt_q  <= FLT_NONE;
                    st     <= ST_SEG;
                end
                ST_SEG: if (mem_ack) begin
                    if (!seg_ok) begin
                        flt_q <= FLT_TABLE;
                        st    <= ST_DONE;
                    end else if (seg_prot) begin
                        flt_q <= FLT_PROT;
                        st    <= ST_DONE;
                    end else begin
                        ptf_q <= seg_frame;
                        st    <= ST_PAGE;
                    end
                end
                ST_PAGE: if (mem_ack) begin
                    if (!pg_ok) begin
                        flt_q <= FLT_PAGE;
                        st    <= ST_DONE;
                    end else if (pg_prot) begin
                        flt_q <= FLT_PROT;
                        st    <= ST_DONE;
                    end else begin
                        pa_q <= {pg_frame, va_q[OFFS_W-1:0]};
                        nc_q <= mem_rdata[NOCACHE_BIT];
                        wb_q <= pg_upd;
                        st   <= pg_chg ? ST_WB : ST_DONE;
                    end
                end
                ST_WB: if (mem_ack) st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // memory port driven from the walk state
    always_comb begin
        mem_req  = (st == ST_SEG) || (st == ST_PAGE) || (st == ST_WB);
        mem_we   = (st == ST_WB);
        mem_addr = (st == ST_SEG) ? seg_addr : pg_addr;
        mem_wdata = wb_q;
    end

    // response outputs
    always_comb begin
        req_ready    = (st == ST_IDLE);
        rsp_done     = (st == ST_DONE);
        rsp_fault    = flt_q;
        rsp_paddr    = pa_q;
        rsp_nocache  = nc_q;
        rsp_fault_va = va_q;
    end
endmodule

// File: rtl/xlat_walker_chk.sv
// Cycle-level properties of the translation walker, observed at its ports.
// Assumes a synchronous active-low reset; bound to every walker instance.
module xlat_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [ADDR_W-1:0]        req_vaddr,
    input logic                     req_super,
    input logic [ADDR_W-OFFS_W-1:0] sup_root,
    input logic [ADDR_W-OFFS_W-1:0] usr_root,
    input logic                     mem_req,
    input logic                     mem_we,
    input logic [ADDR_W-1:0]        mem_addr,
    input logic [ADDR_W-1:0]        mem_wdata,
    input logic                     mem_ack,
    input logic                     rsp_done,
    input logic [1:0]               rsp_fault,
    input logic [ADDR_W-1:0]        rsp_paddr,
    input logic [ADDR_W-1:0]        rsp_fault_va
);
    import xw_pkg::*;

    logic [ADDR_W-1:0] va_l;
    logic [ADDR_W-1:0] last_rd;
    logic              wr_seen;

    // track the accepted address, the last read and writes in the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_l    <= '0;
            last_rd <= '0;
            wr_seen <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                va_l    <= req_vaddr;
                wr_seen <= 1'b0;
            end
            if (mem_req && mem_ack && mem_we)  wr_seen <= 1'b1;
            if (mem_req && mem_ack && !mem_we) last_rd <= mem_addr;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    p_seg_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
        (mem_req && !mem_we &&
         mem_addr[ADDR_W-1:OFFS_W] == ($past(req_super) ? $past(sup_root) : $past(usr_root)) &&
         mem_addr[OFFS_W-1:0] == OFFS_W'({$past(req_vaddr[ADDR_W-1 -: IDX_W]), 2'b00})));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_pa_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault == 2'd0) |-> (rsp_paddr[OFFS_W-1:0] == va_l[OFFS_W-1:0]));

    p_wb_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == last_rd && mem_wdata[REF_BIT]));

    p_fault_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault != 2'd0) |-> (!wr_seen && rsp_fault_va == va_l));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> !req_ready);
endmodule

bind xlat_walker xlat_walker_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_super(req_super), .sup_root(sup_root),
    .usr_root(usr_root), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .rsp_done(rsp_done),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_fault_va(rsp_fault_va)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_super = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] sup_root = 20'h00001;
    logic [19:0] usr_root = 20'h00002;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic        rsp_nocache;
    logic [31:0] rsp_fault_va;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [4096];
    int          lat = 0;
    int          wait_cnt = 0;
    int          nrd = 0;
    int          nwr = 0;
    logic [31:0] rd_log [4];
    logic [31:0] wr_addr;

    logic [1:0]  got_flt;
    logic [31:0] got_pa, got_va;
    logic        got_nc;

    always #2 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_super(req_super), .req_write(req_write),
        .sup_root(sup_root), .usr_root(usr_root), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_done(rsp_done),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache),
        .rsp_fault_va(rsp_fault_va)
    );

    // word memory model, acting on the falling edge
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                mem_ack  = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_addr = mem_addr;
                    nwr++;
                end else begin
                    mem_rdata = mem[mem_addr[13:2]];
                    if (nrd < 4) rd_log[nrd] = mem_addr;
                    nrd++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one complete walk; results captured on the done cycle
    task automatic walk(input logic [31:0] va, input logic sup, input logic wr);
        int cyc;
        nrd = 0;
        nwr = 0;
        @(negedge clk);
        req_vaddr = va;
        req_super = sup;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk("walk completes", {31'd0, rsp_done}, 32'd1);
        got_flt = rsp_fault;
        got_pa  = rsp_paddr;
        got_va  = rsp_fault_va;
        got_nc  = rsp_nocache;
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 done low after reset", {31'd0, rsp_done}, 32'd0);
        chk("R1 no memory request after reset", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_read_sup();
        lat = 1;
        walk(32'h01407ABC, 1'b1, 1'b0);
        chk("R2 first read address", rd_log[0], 32'h00001014);
        chk("R3 second read address", rd_log[1], 32'h0000301C);
        chk("R7 fault none", {30'd0, got_flt}, 32'd0);
        chk("R7 physical address", got_pa, 32'hFF880ABC);
        chk("R7 cache inhibit", {31'd0, got_nc}, 32'd1);
        chk("R8 one write-back", nwr, 32'd1);
        chk("R8 write-back address", wr_addr, 32'h0000301C);
        chk("R8 reference set", mem[12'hC07], 32'hFF880049);
        lat = 0;
    endtask

    task automatic t_read_again();
        walk(32'h01407ABC, 1'b1, 1'b0);
        chk("R8 no write when flags unchanged", nwr, 32'd0);
        chk("R7 physical address repeat", got_pa, 32'hFF880ABC);
    endtask

    task automatic t_write();
        walk(32'h01407ABC, 1'b1, 1'b1);
        chk("R8 write sets modify", mem[12'hC07], 32'hFF880059);
        chk("R8 write-back on first write", nwr, 32'd1);
        chk("R7 fault none on write", {30'd0, got_flt}, 32'd0);
        walk(32'h01407ABC, 1'b1, 1'b1);
        chk("R8 no write on second write", nwr, 32'd0);
    endtask

    task automatic t_seg_invalid();
        walk(32'h01807004, 1'b1, 1'b0);
        chk("R4 table fault", {30'd0, got_flt}, 32'd1);
        chk("R4 single read", nrd, 32'd1);
        chk("R9 fault address", got_va, 32'h01807004);
        chk("R9 no write", nwr, 32'd0);
    endtask

    task automatic t_page_invalid();
        walk(32'h01408044, 1'b1, 1'b0);
        chk("R5 page fault", {30'd0, got_flt}, 32'd2);
        chk("R5 two reads", nrd, 32'd2);
        chk("R5 no write", nwr, 32'd0);
        chk("R9 fault address", got_va, 32'h01408044);
    endtask

    task automatic t_seg_ro();
        walk(32'h02407005, 1'b1, 1'b1);
        chk("R6 segment protection fault", {30'd0, got_flt}, 32'd3);
        chk("R6 segment fault after one read", nrd, 32'd1);
        walk(32'h02407005, 1'b1, 1'b0);
        chk("R6 read through read-only segment", {30'd0, got_flt}, 32'd0);
        chk("R6 read through read-only segment address", got_pa, 32'hFF880005);
    endtask

    task automatic t_pg_ro();
        walk(32'h0140A010, 1'b1, 1'b1);
        chk("R6 page protection fault", {30'd0, got_flt}, 32'd3);
        chk("R6 no write on page protection", nwr, 32'd0);
        chk("R6 entry unchanged", mem[12'hC0A], 32'h00ABC005);
    endtask

    task automatic t_user();
        walk(32'h01407ABC, 1'b0, 1'b0);
        chk("R2 user root selects invalid entry", {30'd0, got_flt}, 32'd1);
        chk("R2 user first read address", rd_log[0], 32'h00002014);
        walk(32'h0040A123, 1'b0, 1'b0);
        chk("R2 user first read address ok", rd_log[0], 32'h00002004);
        chk("R7 user physical address", got_pa, 32'h00ABC123);
        chk("R7 user cache inhibit clear", {31'd0, got_nc}, 32'd0);
        chk("R8 reference on read-only page", mem[12'hC0A], 32'h00ABC00D);
    endtask

    task automatic t_busy();
        int cyc;
        lat = 2;
        nrd = 0;
        nwr = 0;
        @(negedge clk);
        req_vaddr = 32'h01407ABC;
        req_super = 1'b1;
        req_write = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_vaddr = 32'h01807004;
        chk("R10 ready low after accept", {31'd0, req_ready}, 32'd0);
        cyc = 0;
        while (!rsp_done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk("R10 ready low at done", {31'd0, req_ready}, 32'd0);
        chk("R10 first request served", rsp_paddr, 32'hFF880ABC);
        @(negedge clk);
        chk("R10 done is one cycle", {31'd0, rsp_done}, 32'd0);
        chk("R10 ready after done", {31'd0, req_ready}, 32'd1);
        chk("R10 busy request not taken", nrd, 32'd2);
        lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[12'h405] = 32'h00003003;
        mem[12'h406] = 32'h00003001;
        mem[12'h409] = 32'h0000300E;
        mem[12'h805] = 32'h00000000;
        mem[12'h801] = 32'h00003002;
        mem[12'hC07] = 32'hFF880041;
        mem[12'hC08] = 32'h12345002;
        mem[12'hC0A] = 32'h00ABC005;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_sup();
        t_read_again();
        t_write();
        t_seg_invalid();
        t_page_invalid();
        t_seg_ro();
        t_pg_ro();
        t_user();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule